// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. It steps a single clock counter through three phases in a fixed order: offset nulling (auto-zero), signal integration, and reference de-integration. It drives one-hot phase-select outputs for the analog switches. During de-integration it watches a synchronized comparator input. It captures the counter value on the first clock at which that input reads low, which marks the zero crossing. When de-integration ends it moves the captured count into an output register.

A run request input selects how conversions are paced. Held high, which is its default level, conversions repeat back to back and every cycle has the same length. Held low, it cuts de-integration short once the crossing has been seen. Auto-zero still runs for its minimum length, and the sequencer then waits in auto-zero until the request returns high. Integration begins seven clocks after that high level is detected. A busy output is high while a conversion is producing data; the result never changes while busy is low. The parameter `RES_BITS` sets the resolution. The intended values are 14 and 16; any value of 5 or more scales every phase the same way.

Top module: `dual_slope_seq`

## Requirements
- R1: With `run_req` high, auto-zero lasts 2^(RES_BITS-1) clocks, integrate 2^(RES_BITS-1) clocks and de-integrate 2^RES_BITS clocks. A full cycle is 2^(RES_BITS+1) clocks: 32768 at 14 bits and 131072 at 16 bits.
- R2: Exactly one of `ph_az`, `ph_int`, `ph_deint` is high in every cycle. While `rst` is high, `ph_az` is high, `busy` is low and `result` is zero.
- R3: `comparator_hi` passes through two flops, so a low level driven in a given cycle is seen by the sequencer two clocks later. The de-integrate count is 0 on the first de-integrate clock. `result` takes the count of the first clock at which the synchronized comparator is low. If it never reads low during de-integration, `result` takes the saturated value 2^RES_BITS-1.
- R4: `result` is loaded only on the clock edge that ends de-integration, and it holds its value through every cycle in which `busy` is low.
- R5: `busy` is high from the first integrate clock through the last de-integrate clock and low in auto-zero.
- R6: If the synchronized run request is low in a de-integrate clock that follows the crossing clock, de-integration ends after that clock. With the request high, de-integration always runs its full length.
- R7: Auto-zero always runs until its count reaches the hold point 2^(RES_BITS-1)-7, which is 8185 at 14 bits and 32761 at 16 bits. While the synchronized request is low, the sequencer stays at that point.
- R8: Integration begins seven clocks after the clock in which the synchronized request is seen high at the hold point, which is nine clocks after `run_req` rises at the pin. An auto-zero therefore lasts at least 2^(RES_BITS-1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req | input | 1 | Run request; high means run continuously, low means hold (asynchronous) |
| comparator_hi | input | 1 | Integrator comparator, high while the integrator output is above zero (asynchronous) |
| ph_az | output | 1 | Auto-zero phase select |
| ph_int | output | 1 | Integrate phase select |
| ph_deint | output | 1 | De-integrate phase select |
| busy | output | 1 | High while a conversion is in progress |
| result | output | RES_BITS | Latched conversion count |

## Verification
Each result has its own latency. A comparator edge shows up in the captured count two clocks after the bench drives it, because of the synchronizer. An early end of de-integration comes one clock after the crossing is captured. A restart is due nine clocks after the run request rises at the pin, or one full auto-zero after it began if that is later. The bench samples on falling edges and counts phase lengths cycle by cycle from the first clock of each phase. Its expected lengths and counts are closed-form functions of the clock on which it changes an input. It sweeps every comparator position across de-integration in a 6-bit configuration, sweeps every restart position across auto-zero, and runs one full 14-bit cycle.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;

    typedef struct packed {
        logic az;
        logic integ;
        logic deint;
    } phase_sel_t;

    // clocks from run-request detection to first integrate clock
    localparam int START_DLY = 7;

    function automatic int az_len(input int res);
        return 1 << (res - 1);
    endfunction

    function automatic int int_len(input int res);
        return 1 << (res - 1);
    endfunction

    function automatic int deint_len(input int res);
        return 1 << res;
    endfunction

    function automatic phase_sel_t decode_phase(input phase_e ph);
        phase_sel_t s;
        s.az    = (ph == PH_AZ);
        s.integ = (ph == PH_INT);
        s.deint = (ph == PH_DEINT);
        return s;
    endfunction

endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/dsq_phase_fsm.sv
module dsq_phase_fsm
    import dsq_pkg::*;
#(
    parameter int RES_BITS = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_s,
    input  logic                crossed,
    output phase_e              phase,
    output logic [RES_BITS-1:0] cnt,
    output logic                load,
    output logic                busy_q
);

    localparam int CW = RES_BITS;
    localparam logic [CW-1:0] AZ_LAST    = CW'(az_len(RES_BITS) - 1);
    localparam logic [CW-1:0] HOLD_PT    = CW'(az_len(RES_BITS) - START_DLY);
    localparam logic [CW-1:0] INT_LAST   = CW'(int_len(RES_BITS) - 1);
    localparam logic [CW-1:0] DEINT_LAST = CW'(deint_len(RES_BITS) - 1);

    phase_e        phase_n;
    logic [CW-1:0] cnt_n;

    always_comb begin
        phase_n = phase;
        cnt_n   = cnt + 1'b1;
        load    = 1'b0;
        unique case (phase)
            PH_AZ: begin
                if (cnt == AZ_LAST) begin
                    phase_n = PH_INT;
                    cnt_n   = '0;
                end else if (cnt == HOLD_PT && !run_s) begin
                    cnt_n   = cnt;
                end
            end
            PH_INT: begin
                if (cnt == INT_LAST) begin
                    phase_n = PH_DEINT;
                    cnt_n   = '0;
                end
            end
            PH_DEINT: begin
                if ((crossed && !run_s) || cnt == DEINT_LAST) begin
                    phase_n = PH_AZ;
                    cnt_n   = '0;
                    load    = 1'b1;
                end
            end
            default: begin
                phase_n = PH_AZ;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_AZ;
            cnt    <= '0;
            busy_q <= 1'b0;
        end else begin
            phase  <= phase_n;
            cnt    <= cnt_n;
            busy_q <= (phase_n != PH_AZ);
        end
    end

    // R8: integrate starts exactly seven clocks after the request was seen high
    a_r8_restart_seven: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_INT) |-> $past(run_s, 7));

    // R7: integrate is only entered from the last auto-zero count
    a_r7_min_az: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_INT) |-> ($past(phase) == PH_AZ && $past(cnt) == AZ_LAST));

    // R1: integrate always spans its full length
    a_r1_int_span: assert property (@(posedge clk) disable iff (rst)
        $fell(phase == PH_INT) |-> ($past(cnt) == INT_LAST && phase == PH_DEINT));

    // R6: crossing seen and request low ends de-integration
    a_r6_early_end: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_DEINT && $past(crossed) && !$past(run_s)) |-> phase == PH_AZ);

endmodule

// File: rtl/dsq_result_latch.sv
module dsq_result_latch
    import dsq_pkg::*;
#(
    parameter int RES_BITS = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  phase_e              phase,
    input  logic [RES_BITS-1:0] cnt,
    input  logic                cmp_s,
    input  logic                load,
    output logic                crossed,
    output logic [RES_BITS-1:0] data_q
);

    logic [RES_BITS-1:0] cap_q;
    logic                cross_now;

    assign cross_now = (phase == PH_DEINT) && !cmp_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            crossed <= 1'b0;
            cap_q   <= '0;
            data_q  <= '0;
        end else begin
            if (phase != PH_DEINT) begin
                crossed <= 1'b0;
            end else if (!crossed && cross_now) begin
                crossed <= 1'b1;
                cap_q   <= cnt;
            end
            if (load) begin
                if (crossed)
                    data_q <= cap_q;
                else if (cross_now)
                    data_q <= cnt;
                else
                    data_q <= '1;
            end
        end
    end

    // R4: output register changes only on a load edge
    a_r4_load_only: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(data_q));

    // R3: a capture only happens inside de-integration
    a_r3_cross_in_deint: assert property (@(posedge clk) disable iff (rst)
        $rose(crossed) |-> $past(phase) == PH_DEINT);

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsq_pkg::*;
#(
    parameter int RES_BITS = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_req,
    input  logic                comparator_hi,
    output logic                ph_az,
    output logic                ph_int,
    output logic                ph_deint,
    output logic                busy,
    output logic [RES_BITS-1:0] result
);

    logic [1:0]          sync_q;
    logic                run_s;
    logic                cmp_s;
    phase_e              phase;
    logic [RES_BITS-1:0] cnt;
    logic                load;
    logic                crossed;
    phase_sel_t          sel;

    dsq_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({run_req, comparator_hi}),
        .q_sync  (sync_q)
    );

    assign run_s = sync_q[1];
    assign cmp_s = sync_q[0];

    dsq_phase_fsm #(.RES_BITS(RES_BITS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .run_s   (run_s),
        .crossed (crossed),
        .phase   (phase),
        .cnt     (cnt),
        .load    (load),
        .busy_q  (busy)
    );

    dsq_result_latch #(.RES_BITS(RES_BITS)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cnt     (cnt),
        .cmp_s   (cmp_s),
        .load    (load),
        .crossed (crossed),
        .data_q  (result)
    );

    assign sel      = decode_phase(phase);
    assign ph_az    = sel.az;
    assign ph_int   = sel.integ;
    assign ph_deint = sel.deint;

    // R2: phase selects are one-hot
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot({ph_az, ph_int, ph_deint}));

    // R5: busy register agrees with the decoded phase
    a_r5_busy_phase: assert property (@(posedge clk) disable iff (rst)
        busy == !ph_az);

    // R4: result holds whenever busy was low
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(result));

endmodule

// File: tb/dual_slope_seq_tb.sv
`timescale 1ns/1ps
module dual_slope_seq_tb;

    localparam int SR       = 6;
    localparam int S_AZ     = 1 << (SR - 1);
    localparam int S_INT    = 1 << (SR - 1);
    localparam int S_DEINT  = 1 << SR;
    localparam int BR       = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          run_s_in = 1'b1, cmp_s_in = 1'b1;
    logic          az_s, int_s, deint_s, busy_s;
    logic [SR-1:0] res_s;

    logic          run_b_in = 1'b1, cmp_b_in = 1'b1;
    logic          az_b, int_b, deint_b, busy_b;
    logic [BR-1:0] res_b;

    int n_vec  = 0;
    int n_fail = 0;

    dual_slope_seq #(.RES_BITS(SR)) u_dut (
        .clk(clk), .rst(rst), .run_req(run_s_in), .comparator_hi(cmp_s_in),
        .ph_az(az_s), .ph_int(int_s), .ph_deint(deint_s), .busy(busy_s), .result(res_s)
    );

    dual_slope_seq u_dut_wide (
        .clk(clk), .rst(rst), .run_req(run_b_in), .comparator_hi(cmp_b_in),
        .ph_az(az_b), .ph_int(int_b), .ph_deint(deint_b), .busy(busy_b), .result(res_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One conversion on the small instance, entered at the negedge of the first
    // integrate clock and left at the negedge of the next one.
    // j: de-integrate clock on which the comparator is pulled low (>= S_DEINT: never)
    // m: auto-zero clock on which run_req is raised (hold mode only)
    task automatic small_conv(input int j, input int m, input bit freerun);
        int n, d, a, exp_res, exp_dl, exp_al, held;
        n = 0;
        while (int_s) begin
            chk(busy_s == 1'b1, "R5 busy in integrate", busy_s, 1);
            n++;
            @(negedge clk);
        end
        chk(n == S_INT, "R1 integrate length", n, S_INT);
        d = 0;
        while (deint_s) begin
            if (d == j) cmp_s_in = 1'b0;
            chk(busy_s == 1'b1 && !az_s && !int_s, "R2/R5 deint select", busy_s, 1);
            d++;
            @(negedge clk);
        end
        exp_res = (j + 2 <= S_DEINT - 1) ? j + 2 : S_DEINT - 1;
        if (freerun) exp_dl = S_DEINT;
        else         exp_dl = (j + 4 <= S_DEINT) ? j + 4 : S_DEINT;
        chk(d == exp_dl, freerun ? "R1 deint full length" : "R6 deint early end", d, exp_dl);
        chk(az_s && !busy_s, "R5 busy low in auto-zero", busy_s, 0);
        chk(int'(res_s) == exp_res, "R3 captured count", int'(res_s), exp_res);
        cmp_s_in = 1'b1;
        held = int'(res_s);
        a = 0;
        while (!int_s) begin
            if (!freerun && a == m) run_s_in = 1'b1;
            chk(int'(res_s) == held && !busy_s, "R4 result stable while idle", int'(res_s), held);
            a++;
            @(negedge clk);
        end
        exp_al = freerun ? S_AZ : ((m + 9 > S_AZ) ? m + 9 : S_AZ);
        chk(a == exp_al, freerun ? "R1 auto-zero length" : "R7/R8 auto-zero and restart",
            a, exp_al);
        if (!freerun) run_s_in = 1'b0;
    endtask

    task automatic small_thread();
        int a;
        a = 0;
        while (!int_s) begin
            a++;
            @(negedge clk);
        end
        chk(a == S_AZ, "R1 first auto-zero length", a, S_AZ);
        // R3/R1: comparator sweep across de-integration, free running
        for (int j = 0; j <= S_DEINT; j++) small_conv(j, 0, 1'b1);
        // R6/R7/R8: hold mode, restart point swept across auto-zero and beyond
        run_s_in = 1'b0;
        for (int m = 0; m <= S_AZ + 6; m++) small_conv(m, m, 1'b0);
        // R7: parked in auto-zero while request stays low
        cmp_s_in = 1'b1;
        while (!az_s) begin
            if (deint_s) cmp_s_in = 1'b0;
            @(negedge clk);
        end
        cmp_s_in = 1'b1;
        repeat (3 * S_AZ) @(negedge clk);
        chk(az_s && !int_s, "R7 parked in auto-zero", az_s, 1);
        run_s_in = 1'b1;
        repeat (8) @(negedge clk);
        chk(!int_s, "R8 no integrate before ninth clock", int_s, 0);
        @(negedge clk);
        chk(int_s && busy_s, "R8 integrate on ninth clock", int_s, 1);
    endtask

    task automatic wide_thread();
        int a, n, d, total;
        a = 0;
        while (!int_b) begin a++; @(negedge clk); end
        chk(a == 8192, "R1 14-bit first auto-zero", a, 8192);
        n = 0;
        while (int_b) begin n++; @(negedge clk); end
        chk(n == 8192, "R1 14-bit integrate", n, 8192);
        d = 0;
        while (deint_b) begin
            if (d == 5000) cmp_b_in = 1'b0;
            d++;
            @(negedge clk);
        end
        cmp_b_in = 1'b1;
        chk(d == 16384, "R1 14-bit deint", d, 16384);
        chk(int'(res_b) == 5002, "R3 14-bit count", int'(res_b), 5002);
        a = 0;
        while (!int_b) begin a++; @(negedge clk); end
        total = n + d + a;
        chk(total == 32768, "R1 14-bit cycle length", total, 32768);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(az_s && !int_s && !deint_s, "R2 reset phase", az_s, 1);
        chk(!busy_s && res_s == '0, "R2 reset busy/result", int'(res_s), 0);
        chk(az_b && !busy_b && res_b == '0, "R2 reset wide", int'(res_b), 0);
        rst = 1'b0;
        fork
            small_thread();
            wide_thread();
        join
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule